// File: doc/BRIEF.md
# DDR2 Power-Up Mode Programming Sequencer

This block runs on the memory controller side and brings a freshly powered DDR2 device into a working state. Software or a boot state machine sets four mode-register words: the base mode word and the three extended mode words. It then pulses `start`. The sequencer first waits through a parameterized quiet interval with the clock enable low. It then issues a fixed list of thirteen commands on the command pins, one command per step. Between steps it inserts the number of clock cycles that the previous command needs to settle.

The list has the following parts:
- a wake-up NOP;
- two precharge-all commands;
- a load of every extended register;
- a mode load that also resets the DLL;
- two refreshes;
- a plain mode load;
- an off-chip-driver default/exit pair built from the user's first extended word.

The list ends with a NOP issued with the clock enable low. After that NOP, `done` rises and stays high. The outputs can be registered or combinational, selected by a parameter.

Top module: `ddr2_boot_seq`

## Requirements
- R1: During and after a synchronous reset, the outputs show NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) with `cke`=0, `ba`=0, `addr`=0, `busy`=0 and `done`=0.
- R2: Take E as the clock edge that samples `start` high while idle. For the next T_START cycles the outputs show NOP with `cke`=0 and `busy`=1. With OUT_REG=1, each port value appears one cycle later than the internal state that produces it.
- R3: Steps 0 to 12 issue, in this order: NOP, PRE, MRS, MRS, MRS, MRS, PRE, REF, REF, MRS, MRS, MRS, NOP. The encodings on {`ras_n`,`cas_n`,`we_n`} are NOP 111, PRE 010, REF 001 and MRS 000, and `cs_n` is always 0. For REF and NOP, `ba` and `addr` are 0.
- R4: Each precharge drives `addr` bit 10 high, every other `addr` bit low, and `ba`=0.
- R5: The mode loads put the following on (`ba`, `addr`), in order: (3, ext3), (2, ext2), (1, ext1), (0, mode OR 0x100), (0, mode), (1, ext1 OR 0x380), (1, ext1).
- R6: The cycle distance from one command to the next is 1 after step 0, T_RP after a precharge, T_MRD after a mode load and T_RFC after a refresh. The cycles in between show NOP with `cke`=1.
- R7: `cke` is 1 for steps 0 to 11 and for the cycles between them. Step 12 is a NOP with `cke`=0.
- R8: The cycle after step 12, `done`=1 and `busy`=0, and the outputs show NOP with `cke`=0. This holds until a reset or a new start.
- R9: A `start` pulse while `busy`=1 has no effect on any output.
- R10: A reset asserted in the middle of the sequence returns the outputs to the R1 state at the next clock edge.
- R11: A `start` while `done`=1 clears `done` and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the sequence (ignored while busy) |
| mode_word | input | ADDR_W | Base mode register value |
| ext1_word | input | ADDR_W | Extended register 1 value |
| ext2_word | input | ADDR_W | Extended register 2 value |
| ext3_word | input | ADDR_W | Extended register 3 value |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address / mode register select |
| addr | output | ADDR_W | Address / mode register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
The bench builds the block with ADDR_W=13 and BANK_W=3, with T_START=3, T_RP=3, T_MRD=2 and T_RFC=5, and keeps the default registered outputs. With these values a whole sequence takes about forty cycles. The bench can therefore compare every output cycle by cycle, across several mode-word patterns, including all ones, where the OR masks add nothing. The short run also allows a separate run with a stray start pulse at every busy cycle, and a reset at many offsets. The three gap values are all different, so a gap taken from the wrong row of the step table shows up as a shifted command.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

   typedef enum logic [1:0] {
      K_NOP = 2'd0,
      K_PRE = 2'd1,
      K_REF = 2'd2,
      K_MRS = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_RUN  = 2'd2,
      PH_FIN  = 2'd3
   } phase_e;

   localparam int NUM_STEPS = 13;
   localparam int STEP_W    = $clog2(NUM_STEPS);
   localparam int LAST_STEP = NUM_STEPS - 1;

   // address bit that turns a precharge into precharge-all
   localparam int AP_BIT = 10;

   localparam logic [15:0] DLL_RST_OR  = 16'h0100;
   localparam logic [15:0] OCD_DFLT_OR = 16'h0380;

   // {ras_n, cas_n, we_n}
   localparam logic [2:0] RCW_NOP = 3'b111;
   localparam logic [2:0] RCW_PRE = 3'b010;
   localparam logic [2:0] RCW_REF = 3'b001;
   localparam logic [2:0] RCW_MRS = 3'b000;

   function automatic logic [2:0] rcw_of(kind_e k);
      case (k)
         K_PRE:   return RCW_PRE;
         K_REF:   return RCW_REF;
         K_MRS:   return RCW_MRS;
         default: return RCW_NOP;
      endcase
   endfunction

endpackage

// File: rtl/ddr2_boot_steps.sv
module ddr2_boot_steps
   import ddr2_boot_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int BANK_W = 3,
   parameter int CNT_W  = 8,
   parameter int T_MRD  = 2,
   parameter int T_RP   = 4,
   parameter int T_RFC  = 26
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic [ADDR_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] ext1_i,
   input  logic [ADDR_W-1:0] ext2_i,
   input  logic [ADDR_W-1:0] ext3_i,
   output kind_e             kind_o,
   output logic              cke_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  gap_o
);

   localparam logic [ADDR_W-1:0] AP_ALL  = ADDR_W'(1) << AP_BIT;
   localparam logic [ADDR_W-1:0] DLL_M   = ADDR_W'(DLL_RST_OR);
   localparam logic [ADDR_W-1:0] OCD_M   = ADDR_W'(OCD_DFLT_OR);
   localparam logic [CNT_W-1:0]  G_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0]  G_MRD   = CNT_W'(T_MRD);
   localparam logic [CNT_W-1:0]  G_RP    = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0]  G_RFC   = CNT_W'(T_RFC);

   always_comb begin
      kind_o = K_NOP;
      cke_o  = 1'b1;
      ba_o   = '0;
      addr_o = '0;
      gap_o  = G_ONE;
      case (step_i)
         STEP_W'(0): begin
            kind_o = K_NOP;
         end
         STEP_W'(1), STEP_W'(6): begin
            kind_o = K_PRE;
            addr_o = AP_ALL;
            gap_o  = G_RP;
         end
         STEP_W'(2): begin
            kind_o = K_MRS;
            ba_o   = BANK_W'(3);
            addr_o = ext3_i;
            gap_o  = G_MRD;
         end
         STEP_W'(3): begin
            kind_o = K_MRS;
            ba_o   = BANK_W'(2);
            addr_o = ext2_i;
            gap_o  = G_MRD;
         end
         STEP_W'(4), STEP_W'(11): begin
            kind_o = K_MRS;
            ba_o   = BANK_W'(1);
            addr_o = ext1_i;
            gap_o  = G_MRD;
         end
         STEP_W'(5): begin
            kind_o = K_MRS;
            addr_o = mode_i | DLL_M;
            gap_o  = G_MRD;
         end
         STEP_W'(7), STEP_W'(8): begin
            kind_o = K_REF;
            gap_o  = G_RFC;
         end
         STEP_W'(9): begin
            kind_o = K_MRS;
            addr_o = mode_i;
            gap_o  = G_MRD;
         end
         STEP_W'(10): begin
            kind_o = K_MRS;
            ba_o   = BANK_W'(1);
            addr_o = ext1_i | OCD_M;
            gap_o  = G_MRD;
         end
         default: begin
            // final NOP with the clock enable dropped
            kind_o = K_NOP;
            cke_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ddr2_boot_fsm.sv
module ddr2_boot_fsm
   import ddr2_boot_pkg::*;
#(
   parameter int T_START = 200,
   parameter int CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CNT_W-1:0]  gap_i,
   output logic [STEP_W-1:0] step_o,
   output logic              issue_o,
   output logic              run_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam logic [CNT_W-1:0]  WAIT_END = CNT_W'(T_START - 1);
   localparam logic [STEP_W-1:0] STEP_END = STEP_W'(LAST_STEP);

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step_q;
   logic              gap_end;

   assign gap_end = (cnt_q == gap_i - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         step_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE, PH_FIN: begin
               if (start) begin
                  phase_q <= PH_WAIT;
                  cnt_q   <= '0;
                  step_q  <= '0;
               end
            end
            PH_WAIT: begin
               if (cnt_q == WAIT_END) begin
                  phase_q <= PH_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               if (gap_end) begin
                  cnt_q <= '0;
                  if (step_q == STEP_END) begin
                     phase_q <= PH_FIN;
                  end else begin
                     step_q <= step_q + STEP_W'(1);
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign step_o  = step_q;
   assign run_o   = (phase_q == PH_RUN);
   assign issue_o = run_o && (cnt_q == '0);
   assign busy_o  = (phase_q == PH_WAIT) || run_o;
   assign done_o  = (phase_q == PH_FIN);

endmodule

// File: rtl/ddr2_boot_drive.sv
module ddr2_boot_drive
   import ddr2_boot_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BANK_W  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_i,
   input  logic              run_i,
   input  kind_e             kind_i,
   input  logic              cke_i,
   input  logic [BANK_W-1:0] ba_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              busy_i,
   input  logic              done_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic [2:0]        rcw_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int VW = 1 + 3 + BANK_W + ADDR_W + 2;

   logic [VW-1:0] nxt;
   logic [VW-1:0] idle_v;

   assign idle_v = {1'b0, RCW_NOP, {BANK_W{1'b0}}, {ADDR_W{1'b0}}, 2'b00};

   always_comb begin
      if (issue_i) begin
         nxt = {cke_i, rcw_of(kind_i), ba_i, addr_i, busy_i, done_i};
      end else begin
         // between commands the clock enable follows the run phase
         nxt = {run_i, RCW_NOP, {BANK_W{1'b0}}, {ADDR_W{1'b0}}, busy_i, done_i};
      end
   end

   logic [VW-1:0] out_v;

   generate
      if (OUT_REG) begin : g_reg
         logic [VW-1:0] out_q;
         always_ff @(posedge clk) begin
            if (rst) out_q <= idle_v;
            else     out_q <= nxt;
         end
         assign out_v = out_q;
      end else begin : g_comb
         assign out_v = rst ? idle_v : nxt;
      end
   endgenerate

   assign cs_n_o = 1'b0;
   assign {cke_o, rcw_o, ba_o, addr_o, busy_o, done_o} = out_v;

endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
   import ddr2_boot_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BANK_W  = 3,
   parameter int T_START = 200,
   parameter int T_MRD   = 2,
   parameter int T_RP    = 4,
   parameter int T_RFC   = 26,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] mode_word,
   input  logic [ADDR_W-1:0] ext1_word,
   input  logic [ADDR_W-1:0] ext2_word,
   input  logic [ADDR_W-1:0] ext3_word,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done
);

   localparam int MAX_A = (T_START > T_MRD) ? T_START : T_MRD;
   localparam int MAX_B = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAX_T + 1);

   generate
      if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 11..16 to carry A10 and the OR masks");
      end
      if (BANK_W < 2) begin : g_bad_bank
         $error("BANK_W must be at least 2 to select four mode registers");
      end
      if (T_START < 1) begin : g_bad_start
         $error("T_START must be at least 1");
      end
      if (T_MRD < 2 || T_RP < 2 || T_RFC < 2) begin : g_bad_gap
         $error("T_MRD, T_RP and T_RFC must each be at least 2");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic              issue;
   logic              run;
   logic              busy_c;
   logic              done_c;
   kind_e             kind;
   logic              step_cke;
   logic [BANK_W-1:0] step_ba;
   logic [ADDR_W-1:0] step_addr;
   logic [CNT_W-1:0]  gap;
   logic [2:0]        rcw;

   ddr2_boot_fsm #(
      .T_START (T_START),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .gap_i   (gap),
      .step_o  (step),
      .issue_o (issue),
      .run_o   (run),
      .busy_o  (busy_c),
      .done_o  (done_c)
   );

   ddr2_boot_steps #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .CNT_W  (CNT_W),
      .T_MRD  (T_MRD),
      .T_RP   (T_RP),
      .T_RFC  (T_RFC)
   ) u_steps (
      .step_i (step),
      .mode_i (mode_word),
      .ext1_i (ext1_word),
      .ext2_i (ext2_word),
      .ext3_i (ext3_word),
      .kind_o (kind),
      .cke_o  (step_cke),
      .ba_o   (step_ba),
      .addr_o (step_addr),
      .gap_o  (gap)
   );

   ddr2_boot_drive #(
      .ADDR_W  (ADDR_W),
      .BANK_W  (BANK_W),
      .OUT_REG (OUT_REG)
   ) u_drive (
      .clk     (clk),
      .rst     (rst),
      .issue_i (issue),
      .run_i   (run),
      .kind_i  (kind),
      .cke_i   (step_cke),
      .ba_i    (step_ba),
      .addr_i  (step_addr),
      .busy_i  (busy_c),
      .done_i  (done_c),
      .cke_o   (cke),
      .cs_n_o  (cs_n),
      .rcw_o   (rcw),
      .ba_o    (ba),
      .addr_o  (addr),
      .busy_o  (busy),
      .done_o  (done)
   );

   assign {ras_n, cas_n, we_n} = rcw;

endmodule

// File: rtl/ddr2_boot_chk.sv
module ddr2_boot_chk #(
   parameter int ADDR_W = 14,
   parameter int BANK_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input logic [ADDR_W-1:0] addr,
   input logic              busy,
   input logic              done
);

   logic [2:0] rcw;
   logic       is_nop;
   logic       is_pre;
   logic       is_ref;
   logic       is_mrs;

   assign rcw    = {ras_n, cas_n, we_n};
   assign is_nop = (rcw == 3'b111);
   assign is_pre = (rcw == 3'b010);
   assign is_ref = (rcw == 3'b001);
   assign is_mrs = (rcw == 3'b000);

   // R3
   legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      !cs_n && (is_nop || is_pre || is_ref || is_mrs));

   // R4
   pre_all_chk: assert property (@(posedge clk) disable iff (rst)
      is_pre |-> (addr[10] && ba == '0));

   // R5
   mrs_sel_chk: assert property (@(posedge clk) disable iff (rst)
      is_mrs |-> (ba < BANK_W'(4)));

   // R6
   ref_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      is_ref |=> is_nop);

   // R6
   mrs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      is_mrs |=> is_nop);

   // R7
   cmd_cke_chk: assert property (@(posedge clk) disable iff (rst)
      !is_nop |-> cke);

   // R8
   busy_done_chk: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (is_nop && !cke));

endmodule

bind ddr2_boot_seq ddr2_boot_chk #(
   .ADDR_W (ADDR_W),
   .BANK_W (BANK_W)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .cke   (cke),
   .cs_n  (cs_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .ba    (ba),
   .addr  (addr),
   .busy  (busy),
   .done  (done)
);

// File: tb/ddr2_boot_seq_tb.sv
module ddr2_boot_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 13;
   localparam int BW   = 3;
   localparam int TS   = 3;
   localparam int TMRD = 2;
   localparam int TRP  = 3;
   localparam int TRFC = 5;
   localparam int LAT  = 1;
   localparam int BASE = TS + 1;
   localparam int VW   = 1 + 1 + 3 + BW + AW + 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [AW-1:0] mode_w = '0, e1_w = '0, e2_w = '0, e3_w = '0;
   logic          cke, cs_n, ras_n, cas_n, we_n, busy, done;
   logic [BW-1:0] ba;
   logic [AW-1:0] addr;

   int checks = 0;
   int errors = 0;
   int pk [0:13];
   bit prev_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr2_boot_seq #(
      .ADDR_W (AW), .BANK_W (BW), .T_START (TS),
      .T_MRD (TMRD), .T_RP (TRP), .T_RFC (TRFC), .OUT_REG (1'b1)
   ) u_dut (
      .clk (clk), .rst (rst), .start (start),
      .mode_word (mode_w), .ext1_word (e1_w), .ext2_word (e2_w), .ext3_word (e3_w),
      .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .ba (ba), .addr (addr), .busy (busy), .done (done)
   );

   function automatic int gap_of(int k);
      if (k == 0 || k == 12) return 1;
      if (k == 1 || k == 6)  return TRP;
      if (k == 7 || k == 8)  return TRFC;
      return TMRD;
   endfunction

   function automatic logic [VW-1:0] vec(logic c, logic [2:0] r, int b,
                                         logic [AW-1:0] a, logic bz, logic dn);
      return {c, 1'b0, r, BW'(b), a, bz, dn};
   endfunction

   // expected port vector for step k when issued
   function automatic logic [VW-1:0] step_vec(int k);
      case (k)
         0:       return vec(1'b1, 3'b111, 0, '0, 1'b1, 1'b0);
         1, 6:    return vec(1'b1, 3'b010, 0, AW'(13'h400), 1'b1, 1'b0);
         2:       return vec(1'b1, 3'b000, 3, e3_w, 1'b1, 1'b0);
         3:       return vec(1'b1, 3'b000, 2, e2_w, 1'b1, 1'b0);
         4, 11:   return vec(1'b1, 3'b000, 1, e1_w, 1'b1, 1'b0);
         5:       return vec(1'b1, 3'b000, 0, mode_w | AW'(13'h100), 1'b1, 1'b0);
         7, 8:    return vec(1'b1, 3'b001, 0, '0, 1'b1, 1'b0);
         9:       return vec(1'b1, 3'b000, 0, mode_w, 1'b1, 1'b0);
         10:      return vec(1'b1, 3'b000, 1, e1_w | AW'(13'h380), 1'b1, 1'b0);
         default: return vec(1'b0, 3'b111, 0, '0, 1'b1, 1'b0);
      endcase
   endfunction

   function automatic string step_tag(int k);
      case (k)
         1, 6:    return "R3/R4 precharge";
         0, 7, 8: return "R3 step";
         12:      return "R7 final NOP";
         default: return "R5 mode load";
      endcase
   endfunction

   task automatic chk(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [VW-1:0] port_vec();
      return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, busy, done};
   endfunction

   // expected vector n edges after the start edge, plus tag
   task automatic expect_at(int n, bit pd, output logic [VW-1:0] e, output string tag);
      int m, r;
      m = n - LAT;
      if (m <= 0) begin
         e = vec(1'b0, 3'b111, 0, '0, 1'b0, pd); tag = "R2 latency";
      end else if (m <= TS) begin
         e = vec(1'b0, 3'b111, 0, '0, 1'b1, 1'b0); tag = "R2 power wait";
      end else begin
         r = m - BASE;
         if (r > pk[12]) begin
            e = vec(1'b0, 3'b111, 0, '0, 1'b0, 1'b1); tag = "R8 done";
         end else begin
            e = vec(1'b1, 3'b111, 0, '0, 1'b1, 1'b0); tag = "R6 gap NOP";
            for (int k = 0; k <= 12; k++) begin
               if (r == pk[k]) begin
                  e = step_vec(k); tag = step_tag(k);
               end
            end
         end
      end
   endtask

   // one sequence; inj = cycle of a stray start (0 none); rst_at = reset cycle (0 none)
   task automatic run_seq(string ctx, int inj, int rst_at);
      logic [VW-1:0] e;
      string tag;
      int total;
      total = LAT + BASE + pk[12] + 3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 1; n <= total; n++) begin
         expect_at(n, prev_done, e, tag);
         chk({ctx, tag}, port_vec(), e);
         if (n == rst_at) begin
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            // R10: back to the idle state one edge later
            chk("R10 reset mid-run", port_vec(), vec(1'b0, 3'b111, 0, '0, 1'b0, 1'b0));
            prev_done = 1'b0;
            return;
         end
         start = (n == inj);
         @(negedge clk);
         start = 1'b0;
      end
      prev_done = 1'b1;
   endtask

   task automatic set_words(int p);
      case (p)
         0: begin mode_w = '0;           e1_w = '0;           e2_w = '0;           e3_w = '0;           end
         1: begin mode_w = '1;           e1_w = '1;           e2_w = '1;           e3_w = '1;           end
         2: begin mode_w = AW'(13'h0a55); e1_w = AW'(13'h1444); e2_w = AW'(13'h0123); e3_w = AW'(13'h1abc); end
         default: begin
            mode_w = AW'(1) << p; e1_w = AW'(1) << (p + 1);
            e2_w = AW'(1) << (p + 2); e3_w = AW'(1) << (p + 3);
         end
      endcase
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      pk[0] = 0;
      for (int k = 1; k <= 13; k++) pk[k] = pk[k-1] + gap_of(k - 1);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset", port_vec(), vec(1'b0, 3'b111, 0, '0, 1'b0, 1'b0));
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle", port_vec(), vec(1'b0, 3'b111, 0, '0, 1'b0, 1'b0));

      // main sweep over word patterns; later runs restart from done (R11)
      for (int p = 0; p < 8; p++) begin
         set_words(p);
         run_seq((p == 0) ? "" : "R11 restart/", 0, 0);
      end

      // R9: stray start at every busy cycle
      set_words(2);
      for (int inj = 1; inj <= BASE + pk[12]; inj++) begin
         run_seq("R9 ignored start/", inj, 0);
      end

      // R10: reset at a range of offsets
      for (int ra = 1; ra <= LAT + BASE + pk[12] + 2; ra += 3) begin
         set_words(ra % 8);
         run_seq("R10 pre-reset/", 0, ra);
         @(negedge clk);
         chk("R10 stays idle", port_vec(), vec(1'b0, 3'b111, 0, '0, 1'b0, 1'b0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule